// File: doc/BRIEF.md
# Stop-Grant Clock Sequencer

This block sits on the processor side of a clock-stop handshake. When the platform raises a stop request, the sequencer waits for an instruction retirement boundary. It then runs a fixed shutdown order: it clears the pipeline, lets any bus cycle or locked operation already under way finish, and waits until the external write buffers report empty. After that it drives one special acknowledge bus cycle with a fixed encoding. When that cycle receives its ready, the sequencer gates the core clock and floats the data and parity bus.

When the stop request is released, the sequencer counts a short, fixed recovery window and then gives control back to normal operation. A halt flag, set by a halt instruction, survives the stop. Wake interrupts that arrive while the core is not in normal operation are held in a latch and presented on the first running cycle, so no wake event is lost.

Top module: `clkstop_sequencer`

## Requirements
- R1: After reset, and whenever reset is applied from any state, the block is running: core_clk_en=1, ads_permit=1, data_float=0, flush_pipe=0, cyc_start=0, cyc_active=0, halted=0, irq_post=0.
- R2: A stop request is never acted on without a retirement boundary. While retire_bnd stays low, flush_pipe stays low however long stop_req is held, and ads_permit drops while the request waits.
- R3: flush_pipe is high for exactly one cycle. That cycle immediately follows the clock edge at which retire_bnd is sampled high while stop_req is (or was already) sampled high.
- R4: The acknowledge cycle does not start while bus_busy=1 or wb_empty=0. It starts, with cyc_start high for its first cycle only, in the cycle after the first edge past the flush at which bus_busy=0 and wb_empty=1 are sampled together.
- R5: While cyc_active=1 the bus encoding is cyc_dc=0, cyc_mio=0, cyc_wr=1, cyc_be=8'hFB and cyc_addr[31:3]=29'h10. While idle it is cyc_dc=0, cyc_mio=0, cyc_wr=0, cyc_be=8'hFF and cyc_addr=0.
- R6: brdy_in sampled high during the acknowledge cycle makes core_clk_en=0 and data_float=1 from the next cycle on. Both hold for as long as stop_req stays high.
- R7: After stop_req is sampled low in the stopped state, ads_permit (if not halted) returns after exactly RESUME_CYC+1 clock edges, which is fewer than 10. ads_permit is high only in normal running with halted=0.
- R8: If stop_req falls before a retirement boundary is seen, the request is abandoned: there is no flush and normal running resumes on the next cycle.
- R9: halt_instr sampled high in normal running sets halted from the next cycle. Any of irq_intr, irq_nmi, irq_init or irq_smi seen in running clears it, and so does reset.
- R10: Wake lines seen outside normal running are latched. In running, irq_post shows the latched bits ORed with the live lines, with bit order [0]=INTR, [1]=NMI, [2]=INIT, [3]=SMI. The latch empties after one running cycle, and irq_post is 0 outside running.
- R11: core_clk_en is high in every state except the stopped one, including the recovery window. data_float is high only in the stopped state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Clock-stop request from the platform |
| retire_bnd | input | 1 | Instruction retirement boundary this cycle |
| bus_busy | input | 1 | A bus cycle or locked operation is still in progress |
| brdy_in | input | 1 | Bus ready |
| wb_empty | input | 1 | External write buffers are empty |
| halt_instr | input | 1 | Halt instruction executed |
| irq_intr | input | 1 | Maskable interrupt wake line |
| irq_nmi | input | 1 | Non-maskable interrupt wake line |
| irq_init | input | 1 | Init wake line |
| irq_smi | input | 1 | System-management interrupt wake line |
| flush_pipe | output | 1 | Invalidate all in-flight instructions |
| cyc_start | output | 1 | First cycle of the acknowledge bus cycle |
| cyc_active | output | 1 | Acknowledge bus cycle outstanding |
| cyc_dc | output | 1 | Data/control indication of the driven cycle |
| cyc_mio | output | 1 | Memory/IO indication of the driven cycle |
| cyc_wr | output | 1 | Write/read indication of the driven cycle |
| cyc_be | output | BE_W | Byte enables of the driven cycle |
| cyc_addr | output | ADDR_W-3 | Address bits [ADDR_W-1:3] of the driven cycle |
| data_float | output | 1 | Float the data and parity bus |
| core_clk_en | output | 1 | Internal core clock enable |
| ads_permit | output | 1 | Core may start bus cycles |
| halted | output | 1 | Halt state |
| irq_post | output | 4 | Wake interrupts presented to the core |

## Verification
The bench holds the stop request for a long time with no retirement boundary, and also drops it before a boundary. A design that acts on the raw request would flush early, and one that forgets the cancel path would hang with address strobes blocked. It stalls the drain step first with a busy bus and then with the write buffers not empty, one condition at a time. A sequencer that checks only one of the two would issue the acknowledge cycle too soon. It measures the recovery window edge by edge, pulses a wake line while the clock is gated, and applies reset in the stopped state. These steps catch a lost interrupt, a recovery window that is off by one, and a reset that leaves the clock gated. It also clears the halt flag with each of the four wake lines in turn.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_ARMED   = 3'd1,
      ST_FLUSH   = 3'd2,
      ST_DRAIN   = 3'd3,
      ST_ACK     = 3'd4,
      ST_STOPPED = 3'd5,
      ST_RESUME  = 3'd6
   } seq_state_e;

   localparam int unsigned WAKE_LINES = 4;
   localparam int unsigned WAKE_INTR  = 0;
   localparam int unsigned WAKE_NMI   = 1;
   localparam int unsigned WAKE_INIT  = 2;
   localparam int unsigned WAKE_SMI   = 3;

   localparam logic [7:0]  ACK_BE   = 8'hFB;
   localparam int unsigned ACK_LINE = 32'h10;

endpackage

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
   import clkstop_pkg::*;
#(
   parameter int unsigned RESUME_CYC = 4,
   parameter int unsigned CNT_W      = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       retire_bnd,
   input  logic       bus_busy,
   input  logic       wb_empty,
   input  logic       brdy_in,
   output seq_state_e state,
   output logic       ack_first
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(RESUME_CYC - 1);

   seq_state_e       nxt;
   logic [CNT_W-1:0] cnt;
   logic             drain_ok;

   assign drain_ok = !bus_busy && wb_empty;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN:     if (stop_req) nxt = retire_bnd ? ST_FLUSH : ST_ARMED;
         ST_ARMED:   if (!stop_req) nxt = ST_RUN;
                     else if (retire_bnd) nxt = ST_FLUSH;
         ST_FLUSH:   nxt = ST_DRAIN;
         ST_DRAIN:   if (drain_ok) nxt = ST_ACK;
         ST_ACK:     if (brdy_in) nxt = ST_STOPPED;
         ST_STOPPED: if (!stop_req) nxt = ST_RESUME;
         ST_RESUME:  if (cnt == LAST) nxt = ST_RUN;
         default:    nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         cnt       <= '0;
         ack_first <= 1'b0;
      end else begin
         state     <= nxt;
         ack_first <= (state == ST_DRAIN) && drain_ok;
         cnt       <= (state == ST_RESUME) ? cnt + 1'b1 : '0;
      end
   end

endmodule

// File: rtl/clkstop_wake.sv
module clkstop_wake #(
   parameter int unsigned LINES = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             halt_instr,
   input  logic [LINES-1:0] lines,
   output logic [LINES-1:0] post,
   output logic             halted
);

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic held;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       held <= 1'b0;
         else if (running) held <= 1'b0;
         else if (lines[i]) held <= 1'b1;
      end
      assign post[i] = running & (held | lines[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       halted <= 1'b0;
      else if (running) halted <= (halted | halt_instr) & ~(|post);
   end

endmodule

// File: rtl/clkstop_ackgen.sv
module clkstop_ackgen
   import clkstop_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BE_W   = 8
)(
   input  logic              active,
   output logic              dc,
   output logic              mio,
   output logic              wr,
   output logic [BE_W-1:0]   be,
   output logic [ADDR_W-1:3] addr
);

   localparam int unsigned       LINE_W   = ADDR_W - 3;
   localparam logic [LINE_W-1:0] LINE_VAL = LINE_W'(ACK_LINE);

   for (genvar b = 0; b < BE_W; b++) begin : g_be
      assign be[b] = active ? ACK_BE[b] : 1'b1;
   end

   for (genvar a = 0; a < LINE_W; a++) begin : g_addr
      assign addr[a+3] = active & LINE_VAL[a];
   end

   assign dc  = 1'b0;
   assign mio = 1'b0;
   assign wr  = active;

endmodule

// File: rtl/clkstop_sequencer.sv
module clkstop_sequencer
   import clkstop_pkg::*;
#(
   parameter int unsigned RESUME_CYC = 4,
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BE_W       = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req,
   input  logic              retire_bnd,
   input  logic              bus_busy,
   input  logic              brdy_in,
   input  logic              wb_empty,
   input  logic              halt_instr,
   input  logic              irq_intr,
   input  logic              irq_nmi,
   input  logic              irq_init,
   input  logic              irq_smi,
   output logic              flush_pipe,
   output logic              cyc_start,
   output logic              cyc_active,
   output logic              cyc_dc,
   output logic              cyc_mio,
   output logic              cyc_wr,
   output logic [BE_W-1:0]   cyc_be,
   output logic [ADDR_W-1:3] cyc_addr,
   output logic              data_float,
   output logic              core_clk_en,
   output logic              ads_permit,
   output logic              halted,
   output logic [3:0]        irq_post
);

   if (RESUME_CYC < 1 || RESUME_CYC > 8) begin : g_bad_resume
      $error("RESUME_CYC must lie in 1..8 to keep recovery under 10 clocks");
   end
   if (RESUME_CYC >= (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for RESUME_CYC");
   end
   if (BE_W != 8) begin : g_bad_be
      $error("BE_W must be 8 for the acknowledge encoding");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small to hold the acknowledge line address");
   end

   seq_state_e            state;
   logic                  running;
   logic [WAKE_LINES-1:0] wake_lines;

   clkstop_ctrl #(
      .RESUME_CYC (RESUME_CYC),
      .CNT_W      (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_req   (stop_req),
      .retire_bnd (retire_bnd),
      .bus_busy   (bus_busy),
      .wb_empty   (wb_empty),
      .brdy_in    (brdy_in),
      .state      (state),
      .ack_first  (cyc_start)
   );

   assign running = (state == ST_RUN);

   assign wake_lines[WAKE_INTR] = irq_intr;
   assign wake_lines[WAKE_NMI]  = irq_nmi;
   assign wake_lines[WAKE_INIT] = irq_init;
   assign wake_lines[WAKE_SMI]  = irq_smi;

   clkstop_wake #(
      .LINES (WAKE_LINES)
   ) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .running    (running),
      .halt_instr (halt_instr),
      .lines      (wake_lines),
      .post       (irq_post),
      .halted     (halted)
   );

   clkstop_ackgen #(
      .ADDR_W (ADDR_W),
      .BE_W   (BE_W)
   ) u_ackgen (
      .active (cyc_active),
      .dc     (cyc_dc),
      .mio    (cyc_mio),
      .wr     (cyc_wr),
      .be     (cyc_be),
      .addr   (cyc_addr)
   );

   assign cyc_active  = (state == ST_ACK);
   assign flush_pipe  = (state == ST_FLUSH);
   assign data_float  = (state == ST_STOPPED);
   assign core_clk_en = (state != ST_STOPPED);
   assign ads_permit  = running && !halted;

endmodule

// File: rtl/clkstop_sva.sv
module clkstop_sva #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BE_W   = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              stop_req,
   input logic              retire_bnd,
   input logic              bus_busy,
   input logic              brdy_in,
   input logic              wb_empty,
   input logic              flush_pipe,
   input logic              cyc_start,
   input logic              cyc_active,
   input logic              cyc_dc,
   input logic              cyc_mio,
   input logic              cyc_wr,
   input logic [BE_W-1:0]   cyc_be,
   input logic [ADDR_W-1:3] cyc_addr,
   input logic              data_float,
   input logic              core_clk_en,
   input logic              ads_permit,
   input logic              halted,
   input logic [3:0]        irq_post
);

   logic       rsm_armed;
   logic [4:0] rsm_gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsm_armed <= 1'b0;
         rsm_gap   <= '0;
      end else if (data_float) begin
         rsm_armed <= 1'b1;
         rsm_gap   <= '0;
      end else if (rsm_armed && (ads_permit || halted)) begin
         rsm_armed <= 1'b0;
      end else if (rsm_armed && rsm_gap != 5'h1f) begin
         rsm_gap <= rsm_gap + 1'b1;
      end
   end

   AST_FLUSH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_pipe) |-> $past(retire_bnd)); // R2

   AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pipe |=> !flush_pipe); // R3

   AST_ACK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |-> $past(!bus_busy && wb_empty)); // R4

   AST_ACK_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_active |-> (!cyc_dc && !cyc_mio && cyc_wr && cyc_be == 8'hFB
                      && cyc_addr == (ADDR_W-3)'(32'h10))); // R5

   AST_GATE_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_active && brdy_in) |=> (!core_clk_en && data_float)); // R6

   AST_GATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_clk_en && stop_req) |=> !core_clk_en); // R6

   AST_RESUME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rsm_armed |-> rsm_gap < 5'd10); // R7

   AST_ADS_QUIET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |-> !ads_permit); // R7

   AST_HALT_NO_ADS: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !ads_permit); // R9

   AST_IRQ_HIDDEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |-> irq_post == 4'h0); // R10

   AST_FLOAT_ONLY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      data_float |-> !core_clk_en); // R11

endmodule

bind clkstop_sequencer clkstop_sva #(
   .ADDR_W (ADDR_W),
   .BE_W   (BE_W)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_req    (stop_req),
   .retire_bnd  (retire_bnd),
   .bus_busy    (bus_busy),
   .brdy_in     (brdy_in),
   .wb_empty    (wb_empty),
   .flush_pipe  (flush_pipe),
   .cyc_start   (cyc_start),
   .cyc_active  (cyc_active),
   .cyc_dc      (cyc_dc),
   .cyc_mio     (cyc_mio),
   .cyc_wr      (cyc_wr),
   .cyc_be      (cyc_be),
   .cyc_addr    (cyc_addr),
   .data_float  (data_float),
   .core_clk_en (core_clk_en),
   .ads_permit  (ads_permit),
   .halted      (halted),
   .irq_post    (irq_post)
);

// File: tb/clkstop_sequencer_test.sv
module clkstop_sequencer_test;

   localparam int RSM = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic stop_req = 0, retire_bnd = 0, bus_busy = 0, brdy_in = 0, wb_empty = 0;
   logic halt_instr = 0, irq_intr = 0, irq_nmi = 0, irq_init = 0, irq_smi = 0;

   logic        flush_pipe, cyc_start, cyc_active, cyc_dc, cyc_mio, cyc_wr;
   logic [7:0]  cyc_be;
   logic [31:3] cyc_addr;
   logic        data_float, core_clk_en, ads_permit, halted;
   logic [3:0]  irq_post;

   clkstop_sequencer #(.RESUME_CYC(RSM)) uut (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .retire_bnd(retire_bnd),
      .bus_busy(bus_busy), .brdy_in(brdy_in), .wb_empty(wb_empty),
      .halt_instr(halt_instr), .irq_intr(irq_intr), .irq_nmi(irq_nmi),
      .irq_init(irq_init), .irq_smi(irq_smi), .flush_pipe(flush_pipe),
      .cyc_start(cyc_start), .cyc_active(cyc_active), .cyc_dc(cyc_dc),
      .cyc_mio(cyc_mio), .cyc_wr(cyc_wr), .cyc_be(cyc_be), .cyc_addr(cyc_addr),
      .data_float(data_float), .core_clk_en(core_clk_en),
      .ads_permit(ads_permit), .halted(halted), .irq_post(irq_post)
   );

   int checks = 0;
   int errors = 0;
   int flush_seen = 0;
   bit cmp_on = 0;
   bit done = 0;

   // Behavioural reference: phase 0 run, 1 waiting, 2 flush, 3 drain,
   // 4 acknowledge, 5 stopped, 6 recovery
   int       m_ph = 0;
   int       m_wait = 0;
   bit       m_halt = 0;
   bit [3:0] m_lat = 0;
   bit       m_first = 0;

   always @(posedge clk) begin
      automatic bit [3:0] wake = {irq_smi, irq_init, irq_nmi, irq_intr};
      if (!rst_n) begin
         m_ph = 0; m_wait = 0; m_halt = 0; m_lat = 0; m_first = 0;
      end else begin
         if (m_ph == 0) begin
            if ((m_lat | wake) != 0) m_halt = 0;
            else if (halt_instr) m_halt = 1;
            m_lat = 0;
         end else begin
            m_lat = m_lat | wake;
         end
         m_first = 0;
         if (m_ph == 0) begin
            if (stop_req) m_ph = retire_bnd ? 2 : 1;
         end else if (m_ph == 1) begin
            if (!stop_req) m_ph = 0;
            else if (retire_bnd) m_ph = 2;
         end else if (m_ph == 2) begin
            m_ph = 3;
         end else if (m_ph == 3) begin
            if (!bus_busy && wb_empty) begin m_ph = 4; m_first = 1; end
         end else if (m_ph == 4) begin
            if (brdy_in) m_ph = 5;
         end else if (m_ph == 5) begin
            if (!stop_req) begin m_ph = 6; m_wait = 0; end
         end else begin
            m_wait++;
            if (m_wait == RSM) m_ph = 0;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (flush_pipe) flush_seen++;
      if (cmp_on && !done) begin
         automatic bit ack = (m_ph == 4);
         automatic bit [3:0] wake = {irq_smi, irq_init, irq_nmi, irq_intr};
         chk("R3", "flush_pipe", flush_pipe, m_ph == 2);
         chk("R4", "cyc_start", cyc_start, m_first);
         chk("R4", "cyc_active", cyc_active, ack);
         chk("R5", "cyc_dc", cyc_dc, 0);
         chk("R5", "cyc_mio", cyc_mio, 0);
         chk("R5", "cyc_wr", cyc_wr, ack);
         chk("R5", "cyc_be", cyc_be, ack ? 8'hFB : 8'hFF);
         chk("R5", "cyc_addr", cyc_addr, ack ? 32'h10 : 32'h0);
         chk("R11", "data_float", data_float, m_ph == 5);
         chk("R11", "core_clk_en", core_clk_en, m_ph != 5);
         chk("R7", "ads_permit", ads_permit, m_ph == 0 && !m_halt);
         chk("R9", "halted", halted, m_halt);
         chk("R10", "irq_post", irq_post, (m_ph == 0) ? (m_lat | wake) : 4'h0);
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      done = 1;
      summary();
   end

   initial begin
      int f0;
      int lat;
      step(3);
      rst_n = 1;
      cmp_on = 1;
      step(1);
      // R1 reset state
      chk("R1", "core_clk_en", core_clk_en, 1);
      chk("R1", "ads_permit", ads_permit, 1);
      chk("R1", "data_float", data_float, 0);
      chk("R1", "cyc_active", cyc_active, 0);
      chk("R1", "halted", halted, 0);

      // R2: request held without a boundary
      f0 = flush_seen;
      stop_req = 1; bus_busy = 1; wb_empty = 0;
      step(6);
      chk("R2", "flush count", flush_seen - f0, 0);
      chk("R2", "ads_permit while waiting", ads_permit, 0);

      // R3: boundary triggers one flush
      retire_bnd = 1; step(1); retire_bnd = 0;
      step(3);
      chk("R3", "flush count", flush_seen - f0, 1);

      // R4: drain waits on busy bus, then on write buffers
      step(3);
      chk("R4", "ack held by busy bus", cyc_active, 0);
      bus_busy = 0;
      step(3);
      chk("R4", "ack held by buffers", cyc_active, 0);
      wb_empty = 1;
      step(1);
      chk("R4", "ack started", cyc_active, 1);
      chk("R5", "ack byte enables", cyc_be, 8'hFB);
      chk("R5", "ack line address", cyc_addr, 32'h10);

      // R6: ready completes acknowledge, clock gated while held
      step(2);
      brdy_in = 1; step(1); brdy_in = 0;
      chk("R6", "core_clk_en", core_clk_en, 0);
      chk("R6", "data_float", data_float, 1);
      irq_nmi = 1; step(1); irq_nmi = 0;
      step(5);
      chk("R6", "gate held", core_clk_en, 0);

      // R7: recovery latency, R10 latched wake presented
      stop_req = 0;
      lat = 0;
      for (int k = 0; k < 20; k++) begin
         step(1);
         lat++;
         if (lat == 1) chk("R11", "clock on in recovery", core_clk_en, 1);
         if (ads_permit) break;
      end
      chk("R7", "recovery clocks", lat, RSM + 1);
      chk("R7", "recovery under 10", lat < 10, 1);
      chk("R10", "latched NMI presented", irq_post, 4'b0010);
      step(1);
      chk("R10", "latch emptied", irq_post, 4'b0000);

      // R8: cancel before boundary
      f0 = flush_seen;
      stop_req = 1; step(2);
      stop_req = 0; step(1);
      chk("R8", "ads back", ads_permit, 1);
      chk("R8", "no flush", flush_seen - f0, 0);

      // R9: halt cleared by each wake line
      for (int w = 0; w < 4; w++) begin
         halt_instr = 1; step(1); halt_instr = 0;
         chk("R9", "halt set", halted, 1);
         chk("R9", "ads blocked", ads_permit, 0);
         {irq_smi, irq_init, irq_nmi, irq_intr} = 4'b0001 << w;
         step(1);
         {irq_smi, irq_init, irq_nmi, irq_intr} = 4'b0000;
         chk("R9", "halt cleared", halted, 0);
         step(1);
      end

      // Halted across a stop, woken by SMI latched while gated
      halt_instr = 1; step(1); halt_instr = 0;
      stop_req = 1; retire_bnd = 1; step(1); retire_bnd = 0;
      step(3); brdy_in = 1; step(1); brdy_in = 0;
      irq_smi = 1; step(1); irq_smi = 0;
      chk("R9", "halt kept while gated", halted, 1);
      stop_req = 0; step(RSM + 2);
      chk("R10", "SMI woke halt", halted, 0);

      // R1: reset applied in stopped state
      stop_req = 1; retire_bnd = 1; step(1); retire_bnd = 0;
      step(3); brdy_in = 1; step(1); brdy_in = 0;
      chk("R6", "gated before reset", core_clk_en, 0);
      rst_n = 0; step(1);
      chk("R1", "clock on under reset", core_clk_en, 1);
      chk("R1", "float off under reset", data_float, 0);
      stop_req = 0; rst_n = 1; step(2);
      chk("R1", "running after reset", ads_permit, 1);

      done = 1;
      summary();
   end

endmodule